// File: doc/BRIEF.md
# CAN FD Transmit Descriptor Fetcher

This block sits between a circular transmit buffer in system memory and a CAN FD frame serializer. Software writes the buffer size in bytes, writes a write offset that marks the end of the frames it has queued, and sets an enable level. The block keeps its own read offset. While enabled and behind the write offset, it fetches the frame at the read offset one 64-bit word at a time over a read port that allows one request in flight. It decodes the header word and passes the frame downstream as one header beat followed by the payload words, on a valid/ready stream.

Every frame starts on a 16-byte slot boundary. A classic frame always takes one slot. An FD frame takes as many slots as its payload needs, and its payload words may run past the end of the buffer and continue from offset 0. When the last beat of a frame is accepted, the read offset moves past all of the frame's slots. If it reaches the buffer size, the size is subtracted from it.

Top module: `canfd_txfetch`

## Requirements
- R1: After reset `rd_ptr` is 0, and `mem_req` and `out_valid` are low.
- R2: A new frame fetch starts only while `cfg_enable` is high and the read offset differs from the write offset. A frame that has already started runs to completion even if `cfg_enable` drops.
- R3: The first 64-bit word of a frame is the header. Bit 63 marks an extended identifier and bit 62 marks a remote request. An extended identifier is bits 61:32 (30 bits). A standard identifier is bits 61:50, zero-extended on `frm_id`. Bits 31:28 are the DLC and bits 27:25 are the option flags on `frm_fdopt`. Flag bit 0 (word bit 25) marks an FD-format frame.
- R4: For an FD-format frame the DLC values 0..15 map to byte lengths 0..8, 12, 16, 20, 24, 32, 48 and 64. For a classic frame a DLC above 8 gives length 8.
- R5: A frame of length L uses 1 + ((L+7)>>4) 16-byte slots if it is FD-format, and 1 slot otherwise. After the frame, `rd_ptr` equals the old offset plus 16 times the slot count, minus the buffer size if the sum reaches the size.
- R6: Payload word k of a frame is read at the frame offset + 8 + 8k. When the next word address reaches the buffer size, it continues from offset 0.
- R7: Each frame appears on the stream as one header beat (`out_first` high, `out_data` = raw header word) followed by ceil(L/8) payload beats. `out_last` is high only on the final beat of the frame.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: A write to the write offset whose low four bits are not zero is ignored.
- R10: A write to the size register sets both offsets to 0 and drops any frame in progress.
- R11: The block has at most one memory read in flight, and every address it issues is 8-byte aligned and below the buffer size.
- R12: `rd_ptr` changes only on the cycle after the last beat of a frame is accepted, or after a size write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Fetch enable level |
| size_we | input | 1 | Size register write strobe |
| size_wdata | input | AW | Buffer size in bytes |
| wptr_we | input | 1 | Write-offset write strobe |
| wptr_wdata | input | AW | New write offset in bytes |
| rd_ptr | output | AW | Current read offset in bytes |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | AW | Byte offset of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data word |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_first | output | 1 | Beat is the header beat |
| out_last | output | 1 | Beat is the final beat of the frame |
| out_data | output | 64 | Header word or payload word |
| frm_ext | output | 1 | Extended identifier flag |
| frm_rtr | output | 1 | Remote request flag |
| frm_id | output | 30 | Decoded identifier |
| frm_fdopt | output | 3 | Option flags, bit 0 = FD format |
| frm_len | output | 7 | Payload length in bytes |

## Verification
The bench places an FD frame in the last slot of the buffer so that its payload runs past the end and the read offset wraps. A design that forgot either wrap would read past the buffer or leave the offset beyond the size. Classic frames with DLC 12 and FD frames with large DLCs are mixed, so swapping the length tables or the slot formula shows up as a wrong beat count or a wrong offset. Further tests check the following cases:
- The disabled state, where a careless design fetches early.
- A misaligned write-offset write, which a careless design accepts and then treats as pending frames.
- A size write, which must clear both offsets.
- A stalling ready pattern, which catches beats that change under backpressure.

// File: rtl/canfd_txf_pkg.sv
// Shared types and helpers for the CAN FD transmit fetcher.
// Assumes 64-bit memory words and 16-byte frame slots.
package canfd_txf_pkg;

    localparam int WORD_BYTES = 8;
    localparam int SLOT_SHIFT = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_HWAIT, ST_HOUT, ST_DREQ, ST_DWAIT, ST_DOUT
    } fetch_state_e;

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [29:0] id;
        logic [2:0]  fdopt;
        logic [6:0]  len;
        logic [3:0]  nwords;
        logic [2:0]  nslots;
    } frame_info_t;

    // Byte length for a DLC code; classic frames clamp at 8.
    function automatic logic [6:0] dlc_to_len(input logic [3:0] dlc, input logic fd);
        logic [6:0] l;
        if (dlc <= 4'd8)   l = {3'b000, dlc};
        else if (!fd)      l = 7'd8;
        else begin
            case (dlc)
                4'd9:    l = 7'd12;
                4'd10:   l = 7'd16;
                4'd11:   l = 7'd20;
                4'd12:   l = 7'd24;
                4'd13:   l = 7'd32;
                4'd14:   l = 7'd48;
                default: l = 7'd64;
            endcase
        end
        return l;
    endfunction

endpackage

// File: rtl/canfd_txf_decode.sv
// Header decoder: turns the upper header bits into frame fields,
// payload word count and slot count. Purely combinational.
// Assumes the header word layout of R3 (word 0 in bits 63:32).
module canfd_txf_decode
    import canfd_txf_pkg::*;
(
    input  logic [63:25] hdr,
    output frame_info_t  info
);
    logic       fd;
    logic [6:0] len;
    logic [7:0] len_rnd;

    // Field extraction and length arithmetic.
    always_comb begin
        fd          = hdr[25];
        len         = dlc_to_len(hdr[31:28], fd);
        len_rnd     = {1'b0, len} + 8'd7;
        info.ext    = hdr[63];
        info.rtr    = hdr[62];
        info.id     = hdr[63] ? hdr[61:32] : {18'd0, hdr[61:50]};
        info.fdopt  = hdr[27:25];
        info.len    = len;
        info.nwords = len_rnd[6:3];
        info.nslots = fd ? (3'd1 + len_rnd[6:4]) : 3'd1;
    end
endmodule

// File: rtl/canfd_txf_ptrs.sv
// Pointer registers: buffer size, write offset and read offset.
// Assumes offsets are byte offsets below the size; a size write
// clears both offsets, misaligned write-offset writes are dropped.
module canfd_txf_ptrs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          size_we,
    input  logic [AW-1:0] size_wdata,
    input  logic          wptr_we,
    input  logic [AW-1:0] wptr_wdata,
    input  logic          adv,
    input  logic [2:0]    adv_slots,
    output logic [AW-1:0] size_q,
    output logic [AW-1:0] wptr_q,
    output logic [AW-1:0] rptr_q
);
    localparam int SW = AW + 1;

    logic [SW-1:0] sum;
    logic [AW-1:0] rptr_nxt;

    // Read offset after a frame, wrapped by subtracting the size.
    always_comb begin
        sum = {1'b0, rptr_q} + (SW'(adv_slots) << canfd_txf_pkg::SLOT_SHIFT);
        if (sum >= {1'b0, size_q}) rptr_nxt = AW'(sum - {1'b0, size_q});
        else                       rptr_nxt = AW'(sum);
    end

    // Register updates; a size write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (size_we) begin
            size_q <= size_wdata;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wptr_we && (wptr_wdata[3:0] == 4'd0)) wptr_q <= wptr_wdata;
            if (adv) rptr_q <= rptr_nxt;
        end
    end
endmodule

// File: rtl/canfd_txf_seq.sv
// Fetch sequencer: reads the header, then each payload word, and
// offers them as stream beats. Keeps one memory read in flight and
// assumes the read data returns some cycles after the request.
module canfd_txf_seq
    import canfd_txf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          enable,
    input  logic [AW-1:0] size_q,
    input  logic [AW-1:0] rptr_q,
    input  logic [AW-1:0] wptr_q,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_first,
    output logic          out_last,
    output logic [63:0]   out_data,
    output frame_info_t   info,
    output logic          adv,
    output logic [2:0]    adv_slots,
    output logic          idle
);
    fetch_state_e  state;
    logic [63:0]   hdr_q;
    logic [63:0]   dat_q;
    logic [AW-1:0] addr_q;
    logic [3:0]    wcnt;
    logic [AW:0]   addr_sum;
    logic [AW-1:0] addr_nxt;
    logic          take;

    canfd_txf_decode u_dec (
        .hdr  (hdr_q[63:25]),
        .info (info)
    );

    // Next word address, wrapping to offset 0 at the buffer end.
    always_comb begin
        addr_sum = {1'b0, addr_q} + (AW+1)'(WORD_BYTES);
        if (addr_sum >= {1'b0, size_q}) addr_nxt = AW'(addr_sum - {1'b0, size_q});
        else                            addr_nxt = AW'(addr_sum);
    end

    // Stream and memory port outputs from the state.
    always_comb begin
        mem_req   = (state == ST_HREQ) || (state == ST_DREQ);
        mem_addr  = addr_q;
        out_valid = (state == ST_HOUT) || (state == ST_DOUT);
        out_first = (state == ST_HOUT);
        out_last  = (state == ST_HOUT) ? (info.nwords == 4'd0) : (wcnt == 4'd1);
        out_data  = (state == ST_HOUT) ? hdr_q : dat_q;
        take      = out_valid && out_ready;
        adv       = take && out_last && !flush;
        adv_slots = info.nslots;
        idle      = (state == ST_IDLE);
    end

    // Frame fetch state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hdr_q  <= '0;
            dat_q  <= '0;
            addr_q <= '0;
            wcnt   <= '0;
        end else if (flush) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (enable && (rptr_q != wptr_q)) begin
                    addr_q <= rptr_q;
                    state  <= ST_HREQ;
                end
                ST_HREQ: state <= ST_HWAIT;
                ST_HWAIT: if (mem_rvalid) begin
                    hdr_q  <= mem_rdata;
                    addr_q <= addr_nxt;
                    state  <= ST_HOUT;
                end
                ST_HOUT: if (take) begin
                    if (info.nwords == 4'd0) state <= ST_IDLE;
                    else begin
                        wcnt  <= info.nwords;
                        state <= ST_DREQ;
                    end
                end
                ST_DREQ: state <= ST_DWAIT;
                ST_DWAIT: if (mem_rvalid) begin
                    dat_q  <= mem_rdata;
                    addr_q <= addr_nxt;
                    state  <= ST_DOUT;
                end
                ST_DOUT: if (take) begin
                    if (wcnt == 4'd1) state <= ST_IDLE;
                    else begin
                        wcnt  <= wcnt - 4'd1;
                        state <= ST_DREQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/canfd_txfetch.sv
// CAN FD transmit descriptor fetcher top. Connects the pointer
// registers to the fetch sequencer and exposes decoded frame fields.
// Assumes software keeps the write offset inside the buffer.
module canfd_txfetch
    import canfd_txf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          size_we,
    input  logic [AW-1:0] size_wdata,
    input  logic          wptr_we,
    input  logic [AW-1:0] wptr_wdata,
    output logic [AW-1:0] rd_ptr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_first,
    output logic          out_last,
    output logic [63:0]   out_data,
    output logic          frm_ext,
    output logic          frm_rtr,
    output logic [29:0]   frm_id,
    output logic [2:0]    frm_fdopt,
    output logic [6:0]    frm_len
);
    logic [AW-1:0] size_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic          adv;
    logic [2:0]    adv_slots;
    logic          seq_idle;
    frame_info_t   info;

    canfd_txf_ptrs #(.AW(AW)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_we    (size_we),
        .size_wdata (size_wdata),
        .wptr_we    (wptr_we),
        .wptr_wdata (wptr_wdata),
        .adv        (adv),
        .adv_slots  (adv_slots),
        .size_q     (size_q),
        .wptr_q     (wptr_q),
        .rptr_q     (rptr_q)
    );

    canfd_txf_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (size_we),
        .enable     (cfg_enable),
        .size_q     (size_q),
        .rptr_q     (rptr_q),
        .wptr_q     (wptr_q),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_first  (out_first),
        .out_last   (out_last),
        .out_data   (out_data),
        .info       (info),
        .adv        (adv),
        .adv_slots  (adv_slots),
        .idle       (seq_idle)
    );

    // Frame field outputs.
    always_comb begin
        rd_ptr    = rptr_q;
        frm_ext   = info.ext;
        frm_rtr   = info.rtr;
        frm_id    = info.id;
        frm_fdopt = info.fdopt;
        frm_len   = info.len;
    end
endmodule

// File: rtl/canfd_txf_chk.sv
// Property checker for the transmit fetcher, bound to the top.
// Assumes the memory answers each request before the next one.
module canfd_txf_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          size_we,
    input logic          cfg_enable,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wr_q,
    input logic [AW-1:0] size_q,
    input logic          seq_idle,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [63:0]   out_data
);
    logic pend;

    // Tracks a read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (mem_req)    pend <= 1'b1;
        else if (mem_rvalid) pend <= 1'b0;
    end

    // R2
    no_fetch_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && (!cfg_enable || rd_ptr == wr_q)) |=> !mem_req);

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !size_we) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    // R11
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend);

    // R11
    addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'd0 && mem_addr < size_q));

    // R12
    rdptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!size_we && !(out_valid && out_ready && out_last)) |=> $stable(rd_ptr));

    // R5
    rdptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr[3:0] == 4'd0) && (size_q == '0 || rd_ptr < size_q));

    // R10
    size_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_we |=> (rd_ptr == '0));
endmodule

bind canfd_txfetch canfd_txf_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_we    (size_we),
    .cfg_enable (cfg_enable),
    .rd_ptr     (rd_ptr),
    .wr_q       (wptr_q),
    .size_q     (size_q),
    .seq_idle   (seq_idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_last   (out_last),
    .out_data   (out_data)
);

// File: tb/sim_canfd_txfetch.sv
module sim_canfd_txfetch;
    localparam int AW  = 16;
    localparam int BUF = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          size_we = 1'b0;
    logic [AW-1:0] size_wdata = '0;
    logic          wptr_we = 1'b0;
    logic [AW-1:0] wptr_wdata = '0;
    logic [AW-1:0] rd_ptr;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [63:0]   mem_rdata;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_first, out_last;
    logic [63:0]   out_data;
    logic          frm_ext, frm_rtr;
    logic [29:0]   frm_id;
    logic [2:0]    frm_fdopt;
    logic [6:0]    frm_len;

    logic [63:0]   mem [0:BUF/8-1];
    int            total = 0;
    int            bad = 0;
    int            ready_cnt = 0;

    logic [63:0]   b_data [0:15];
    logic          b_first [0:15];
    logic          b_last [0:15];
    logic          h_ext, h_rtr;
    logic [29:0]   h_id;
    logic [2:0]    h_fdopt;
    logic [6:0]    h_len;
    logic [AW-1:0] rd_after;

    always #5 clk = ~clk;

    canfd_txfetch #(.AW(AW)) u0 (.*);

    // Memory model: answers each request on the next cycle.
    always_ff @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[7:3]];
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int dlc, input bit fd);
        int t[16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12, 16, 20, 24, 32, 48, 64};
        if (fd) return t[dlc];
        return (dlc > 8) ? 8 : dlc;
    endfunction

    function automatic int exp_slots(input int len, input bit fd);
        return fd ? 1 + ((len + 7) >> 4) : 1;
    endfunction

    // Places a frame at byte offset off; payload words wrap in the buffer.
    task automatic put_frame(input int off, input bit ext, input bit rtr, input int id,
                             input logic [2:0] opt, input int dlc, input int seed);
        logic [29:0] idf;
        int len;
        idf = ext ? 30'(id) : {12'(id), 18'd0};
        mem[off/8] = {ext, rtr, idf, 4'(dlc), opt, 25'd0};
        len = exp_len(dlc, opt[0]);
        for (int k = 0; k < (len + 7) / 8; k++)
            mem[((off + 8 + 8 * k) % BUF) / 8] = {32'(seed), 32'(k)};
    endtask

    task automatic write_wptr(input int v);
        @(negedge clk); wptr_we = 1'b1; wptr_wdata = AW'(v);
        @(negedge clk); wptr_we = 1'b0;
    endtask

    task automatic write_size(input int v);
        @(negedge clk); size_we = 1'b1; size_wdata = AW'(v);
        @(negedge clk); size_we = 1'b0;
    endtask

    // Collects n beats; stall makes ready low on some cycles (R8 hold check).
    task automatic recv(input int n, input bit stall);
        logic pend = 1'b0;
        logic [63:0] pdata = '0;
        for (int i = 0; i < n; i++) begin
            forever begin
                @(negedge clk);
                ready_cnt++;
                if (pend) check("R8 hold", {63'd0, out_valid} | ((out_data == pdata) ? 64'd0 : 64'd2), 64'd1);
                if (mem_req) check("R11 addr", {63'd0, (mem_addr[2:0] == 0 && mem_addr < BUF)}, 64'd1);
                out_ready = stall ? (ready_cnt % 3 == 0) : 1'b1;
                pend  = out_valid && !out_ready;
                pdata = out_data;
                if (out_valid && out_ready) begin
                    b_data[i] = out_data; b_first[i] = out_first; b_last[i] = out_last;
                    if (i == 0) begin
                        h_ext = frm_ext; h_rtr = frm_rtr; h_id = frm_id;
                        h_fdopt = frm_fdopt; h_len = frm_len;
                    end
                    break;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        rd_after = rd_ptr;
    endtask

    // Receives one frame and compares every beat and the new read offset.
    task automatic expect_frame(input string tag, input bit ext, input bit rtr, input int id,
                                input logic [2:0] opt, input int dlc, input int seed,
                                input int start, input bit stall);
        int len, nw, nrd;
        len = exp_len(dlc, opt[0]);
        nw  = (len + 7) / 8;
        nrd = start + 16 * exp_slots(len, opt[0]);
        if (nrd >= BUF) nrd -= BUF;
        recv(nw + 1, stall);
        check({tag, " R3 ext"}, {63'd0, h_ext}, {63'd0, ext});
        check({tag, " R3 rtr"}, {63'd0, h_rtr}, {63'd0, rtr});
        check({tag, " R3 id"}, {34'd0, h_id}, ext ? 64'(id) : 64'(id & 12'hfff));
        check({tag, " R3 opt"}, {61'd0, h_fdopt}, {61'd0, opt});
        check({tag, " R4 len"}, {57'd0, h_len}, 64'(len));
        check({tag, " R7 first"}, {63'd0, b_first[0]}, 64'd1);
        for (int k = 0; k <= nw; k++)
            check({tag, " R7 last"}, {63'd0, b_last[k]}, {63'd0, k == nw});
        for (int k = 0; k < nw; k++)
            check({tag, " R6 payload"}, b_data[k + 1], {32'(seed), 32'(k)});
        check({tag, " R5 rd_ptr"}, 64'(rd_after), 64'(nrd));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd_ptr", 64'(rd_ptr), 64'd0);
        check("R1 mem_req", {63'd0, mem_req}, 64'd0);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_classic();
        put_frame(0, 0, 0, 'h5A3, 3'b000, 5, 'h11);
        write_wptr(16);
        expect_frame("classic", 0, 0, 'h5A3, 3'b000, 5, 'h11, 0, 0);
    endtask

    task automatic t_clamp();
        put_frame(16, 1, 0, 'h1234567, 3'b110, 12, 'h22);
        write_wptr(32);
        expect_frame("clamp R4", 1, 0, 'h1234567, 3'b110, 12, 'h22, 16, 0);
    endtask

    task automatic t_remote();
        put_frame(32, 1, 1, 'h3ABCDEF0, 3'b000, 0, 'h33);
        write_wptr(48);
        expect_frame("remote R7", 1, 1, 'h3ABCDEF0, 3'b000, 0, 'h33, 32, 0);
    endtask

    task automatic t_fd64_stall();
        put_frame(48, 0, 0, 'h7FF, 3'b001, 15, 'h44);
        write_wptr(128);
        expect_frame("fd64 R8", 0, 0, 'h7FF, 3'b001, 15, 'h44, 48, 1);
    endtask

    task automatic t_disabled();
        int seen = 0;
        cfg_enable = 1'b0;
        put_frame(128, 0, 0, 'h12, 3'b000, 2, 'h55);
        write_wptr(144);
        repeat (20) begin
            @(negedge clk);
            if (mem_req || out_valid) seen++;
        end
        check("R2 idle while off", 64'(seen), 64'd0);
        check("R2 rd_ptr", 64'(rd_ptr), 64'd128);
        cfg_enable = 1'b1;
        expect_frame("enable R2", 0, 0, 'h12, 3'b000, 2, 'h55, 128, 0);
    endtask

    task automatic t_misaligned();
        int seen = 0;
        write_wptr(152);
        repeat (15) begin
            @(negedge clk);
            if (mem_req || out_valid) seen++;
        end
        check("R9 ignored write", 64'(seen), 64'd0);
        check("R9 rd_ptr", 64'(rd_ptr), 64'd144);
    endtask

    task automatic t_wrap();
        put_frame(144, 0, 0, 'h101, 3'b001, 9, 'h66);
        put_frame(176, 1, 0, 'h202, 3'b011, 14, 'h77);
        put_frame(240, 0, 0, 'h303, 3'b001, 12, 'h88);
        write_wptr(16);
        expect_frame("queue1", 0, 0, 'h101, 3'b001, 9, 'h66, 144, 0);
        expect_frame("queue2", 1, 0, 'h202, 3'b011, 14, 'h77, 176, 1);
        expect_frame("wrap R6", 0, 0, 'h303, 3'b001, 12, 'h88, 240, 0);
    endtask

    task automatic t_size_reset();
        int seen = 0;
        write_size(BUF);
        @(negedge clk);
        check("R10 rd_ptr", 64'(rd_ptr), 64'd0);
        repeat (8) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check("R10 write offset cleared", 64'(seen), 64'd0);
        put_frame(0, 0, 0, 'h0AA, 3'b001, 10, 'h99);
        write_wptr(32);
        expect_frame("after size R10", 0, 0, 'h0AA, 3'b001, 10, 'h99, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < BUF / 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        write_size(BUF);
        cfg_enable = 1'b1;
        t_classic();
        t_clamp();
        t_remote();
        t_fd64_stall();
        t_disabled();
        t_misaligned();
        t_wrap();
        t_size_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule